// File: doc/BRIEF.md
# Iterative restoring integer divider

A multicycle 32-bit integer divider that produces one quotient bit per clock by restoring shift-and-subtract. A one-cycle start pulse, taken while the unit is idle, captures the dividend, the divisor and a 6-bit function code. Code 0x25 asks for a signed quotient. Every other code, including the usual unsigned code 0x24, gives an unsigned quotient.

For signed work the unit first takes the magnitudes of both operands and records the sign the result will need. It then runs the unsigned loop. The dividend and the quotient share one left-shifting register, and the partial remainder starts at zero. After 32 iterations, one extra cycle negates the quotient when the recorded sign is set. The result then appears on the quotient output together with a one-cycle done pulse. The remainder is never returned, and a zero divisor raises no trap.

Top module: `iter_div`

## Requirements
- R1: While rst_ni is low and after reset, busy_o and done_o are 0 and quotient_o is 0.
- R2: With func_i = 0x24, quotient_o is the unsigned floor of dividend_i / divisor_i for a nonzero divisor.
- R3: With func_i = 0x25, operands are two's-complement and the quotient truncates toward zero. It is negative exactly when bit 31 of dividend_i XOR divisor_i is 1 and the magnitude quotient is nonzero.
- R4: Any func_i value other than 0x25 (for example 0x00 or 0x3F) gives the unsigned quotient of R2.
- R5: In signed mode 0x80000000 is treated as magnitude 2^31. So 0x80000000 / 0xFFFFFFFF gives 0x80000000, and 0x80000000 / 2 gives 0xC0000000.
- R6: A zero divisor produces a magnitude quotient of 0xFFFFFFFF. Unsigned, this gives 0xFFFFFFFF. Signed, this gives 0xFFFFFFFF when the dividend is nonnegative and 0x00000001 when it is negative.
- R7: A start taken at clock edge E makes busy_o high from E until edge E+33. At E+33 busy_o falls and done_o rises, and done_o stays high for that single cycle.
- R8: start_i while busy_o is high is ignored, and changes on dividend_i, divisor_i and func_i while busy have no effect on the result. A start in the cycle where done_o is high is accepted.
- R9: quotient_o changes only at the edge that raises done_o, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken when idle |
| func_i | input | 6 | Function code; 0x25 signed, others unsigned |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| quotient_o | output | 32 | Quotient, held until the next result |

## Verification
The unsigned checks use small exact and inexact quotients, an all-ones dividend, and a divisor larger than the dividend. Together they separate a correct compare-and-subtract from off-by-one shift and compare errors. The signed checks cover all four sign combinations and an inexact negative case, which shows the rounding direction and the sign rule. The most negative operand and zero divisors, under both modes and both dividend signs, exercise the magnitude edges. A second start and operand changes in mid-run, plus a start on the done cycle, show that operands are captured only at acceptance and that the timing stays fixed.

// File: rtl/div_pkg.sv
package div_pkg;
  localparam int unsigned FUNC_W = 6;
  localparam logic [FUNC_W-1:0] FN_DIVU = 6'h24;
  localparam logic [FUNC_W-1:0] FN_DIVS = 6'h25;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/div_prep.sv
module div_prep #(
  parameter int unsigned W = 32
) (
  input  logic         signed_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_o
);
  // most negative value negates to itself and is then read as unsigned 2^(W-1)
  always_comb begin
    mag_a_o = (signed_i && a_i[W-1]) ? (~a_i + 1'b1) : a_i;
    mag_b_o = (signed_i && b_i[W-1]) ? (~b_i + 1'b1) : b_i;
    neg_o   = signed_i & (a_i[W-1] ^ b_i[W-1]);
  end
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] dq_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] dq_o
);
  logic [W:0] shifted;
  logic [W:0] diff;
  logic       ge;

  always_comb begin
    shifted = {rem_i, dq_i[W-1]};
    diff    = shifted - {1'b0, dvs_i};
    ge      = (shifted >= {1'b0, dvs_i});
    rem_o   = ge ? diff[W-1:0] : shifted[W-1:0];
    dq_o    = {dq_i[W-2:0], ge};
  end
endmodule

// File: rtl/iter_div.sv
module iter_div
  import div_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [W-1:0]      dividend_i,
  input  logic [W-1:0]      divisor_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [W-1:0]      quotient_o
);
  localparam int unsigned CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  div_state_e       state_q;
  logic [W-1:0]     rem_q, dq_q, dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             neg_q;

  logic [W-1:0] mag_a, mag_b, rem_nx, dq_nx;
  logic         neg_nx;

  div_prep #(.W(W)) u_prep (
    .signed_i (func_i == FN_DIVS),
    .a_i      (dividend_i),
    .b_i      (divisor_i),
    .mag_a_o  (mag_a),
    .mag_b_o  (mag_b),
    .neg_o    (neg_nx)
  );

  div_step #(.W(W)) u_step (
    .rem_i (rem_q),
    .dq_i  (dq_q),
    .dvs_i (dvs_q),
    .rem_o (rem_nx),
    .dq_o  (dq_nx)
  );

  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rem_q      <= '0;
      dq_q       <= '0;
      dvs_q      <= '0;
      cnt_q      <= '0;
      neg_q      <= 1'b0;
      done_o     <= 1'b0;
      quotient_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          rem_q   <= '0;
          dq_q    <= mag_a;
          dvs_q   <= mag_b;
          neg_q   <= neg_nx;
          cnt_q   <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          rem_q <= rem_nx;
          dq_q  <= dq_nx;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FIX;
        end
        ST_FIX: begin
          quotient_o <= neg_q ? (~dq_q + 1'b1) : dq_q;
          done_o     <= 1'b1;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R7
  AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R8
  AST_RUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |=> busy_o); // R8
  AST_Q_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(quotient_o)); // R9
  AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && dvs_q != '0) |-> (rem_q < dvs_q)); // R2
endmodule

// File: tb/tb_iter_div.sv
`timescale 1ns/1ps
module tb_iter_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  func = 6'h24;
  logic [31:0] a = '0, b = '0;
  logic        busy, done;
  logic [31:0] q;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  iter_div dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .func_i(func),
    .dividend_i(a), .divisor_i(b), .busy_o(busy), .done_o(done), .quotient_o(q)
  );

  function automatic logic [31:0] ref_q(logic [5:0] f, logic [31:0] x, logic [31:0] y);
    logic        sg;
    logic [31:0] mx, my, uq;
    sg = (f == 6'h25);
    mx = (sg && x[31]) ? 32'(0 - x) : x;
    my = (sg && y[31]) ? 32'(0 - y) : y;
    uq = (my == 0) ? 32'hFFFF_FFFF : mx / my;
    return (sg && (x[31] ^ y[31])) ? 32'(0 - uq) : uq;
  endfunction

  // behavioural model
  logic        m_busy = 1'b0, m_done = 1'b0;
  logic [31:0] m_q = '0, m_pend = '0;
  int          m_cnt = 0;
  string       m_tag = "R1", m_pend_tag = "R1", next_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_q <= '0; m_cnt <= 0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy) begin
        if (start) begin
          m_busy <= 1'b1; m_cnt <= 0;
          m_pend <= ref_q(func, a, b); m_pend_tag <= next_tag;
        end
      end else begin
        m_cnt <= m_cnt + 1;
        if (m_cnt + 1 == 33) begin
          m_busy <= 1'b0; m_done <= 1'b1; m_q <= m_pend; m_tag <= m_pend_tag;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h at cycle %0d", tag, what, got, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R7", {31'd0, busy}, {31'd0, m_busy}, "busy_o");
      chk("R7", {31'd0, done}, {31'd0, m_done}, "done_o");
      chk(m_done ? m_tag : "R9", q, m_q, "quotient_o");
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL R7 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_op(logic [5:0] f, logic [31:0] x, logic [31:0] y, string tag);
    @(negedge clk);
    func = f; a = x; b = y; start = 1'b1; next_tag = tag;
    @(negedge clk);
    start = 1'b0;
    while (!m_done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {30'd0, busy, done}, 32'd0, "busy/done in reset");
    chk("R1", q, 32'd0, "quotient in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_op(6'h24, 32'd100, 32'd7, "R2");
    run_op(6'h24, 32'd43, 32'd7, "R2");
    run_op(6'h24, 32'hFFFF_FFFF, 32'd1, "R2");
    run_op(6'h24, 32'd5, 32'd9, "R2");
    run_op(6'h24, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
    run_op(6'h24, 32'h8000_0000, 32'd3, "R2");
    run_op(6'h24, 32'hDEAD_BEEF, 32'h0001_2345, "R2");

    run_op(6'h25, -32'sd43, 32'd7, "R3");
    run_op(6'h25, 32'd43, -32'sd7, "R3");
    run_op(6'h25, -32'sd43, -32'sd7, "R3");
    run_op(6'h25, -32'sd7, 32'd2, "R3");
    run_op(6'h25, -32'sd3, 32'd5, "R3");

    run_op(6'h00, -32'sd43, 32'd7, "R4");
    run_op(6'h3F, -32'sd43, -32'sd7, "R4");

    run_op(6'h25, 32'h8000_0000, 32'hFFFF_FFFF, "R5");
    run_op(6'h25, 32'h8000_0000, 32'd2, "R5");
    run_op(6'h25, 32'd7, 32'h8000_0000, "R5");
    run_op(6'h25, 32'h8000_0000, 32'h8000_0000, "R5");

    run_op(6'h24, 32'd5, 32'd0, "R6");
    run_op(6'h25, -32'sd5, 32'd0, "R6");
    run_op(6'h25, 32'd5, 32'd0, "R6");

    // R8: second start and operand changes while busy are ignored
    @(negedge clk);
    func = 6'h24; a = 32'd1000; b = 32'd10; start = 1'b1; next_tag = "R8";
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    func = 6'h25; a = -32'sd9; b = 32'd2; start = 1'b1; next_tag = "R8 ignored";
    @(negedge clk); start = 1'b0; a = 32'd1; b = 32'd1;
    while (!m_done) @(negedge clk);
    chk("R8", q, 32'd100, "quotient after ignored start");
    // R8: start in the done cycle is accepted
    func = 6'h24; a = 32'd81; b = 32'd9; start = 1'b1; next_tag = "R8";
    @(negedge clk); start = 1'b0;
    chk("R8", {31'd0, busy}, 32'd1, "busy after start on done cycle");
    while (!m_done) @(negedge clk);
    chk("R8", q, 32'd9, "quotient of back-to-back op");
    repeat (4) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule